// File: doc/BRIEF.md
# Burst-Mode Ping-Pong Line Framer

This block is the terminal-side framer of a two-wire line shared in time between the exchange and the terminal. The exchange sends a burst every repetition period. The terminal waits for that burst to finish, keeps the line quiet for a guard interval, and then answers with its own burst. Each burst carries one framing mark and then 36 payload bits: 16 bits for each of two bearer channels (B1, B2) and 4 bits for a signalling channel (D). The line rate is 384 kbit/s, which gives 96 bit periods per 250 µs repetition period.

Line symbols are three-level alternate-mark-inversion codes. A zero is the neutral level. A one is a full-width pulse whose polarity is the opposite of the previous pulse. The block generates the line bit clock from the system clock. It decodes incoming bursts into parallel channel words and encodes the locally loaded channel words into the outgoing burst. A loss-of-frame flag holds transmission back whenever the exchange has gone silent for longer than one repetition period.

Top module: `pingpong_framer`

## Requirements
- R1: While reset is held and on the first cycle after it is released, tx_sym is 00, lof is 1 and rx_valid is 0.
- R2: line_tick is a one-clock pulse every CLKS_PER_BIT clocks. rx_sym is sampled, and tx_sym changes, only on a clock edge at which line_tick is high.
- R3: While the block waits for a burst, a sampled rx_sym other than 00 is taken as the framing mark. The next 36 sampled symbols are payload bits, decoded as 1 for any non-00 symbol and 0 for 00.
- R4: The payload order, used for both directions, is two repeats of: 8 B1 bits, 8 B2 bits, 2 D bits. Each channel word is sent most significant bit first. After the last payload bit is sampled, rx_b1, rx_b2 and rx_d hold the decoded burst, and rx_valid is high for exactly one clock.
- R5: tx_sym stays 00 during the guard. The outgoing framing mark appears on the 6th bit tick (GUARD_BITS) after the tick that sampled the last received payload bit.
- R6: The outgoing burst is one framing mark (logical 1) followed by the 36 payload bits in the R4 order. tx_sym returns to 00 on the next bit tick.
- R7: The symbol codes are 00 = zero, 01 = positive pulse and 10 = negative pulse, and 11 is never driven. Successive marks on tx_sym alternate in polarity across burst boundaries, and the first mark after reset is positive.
- R8: A pulse on tx_load latches tx_b1, tx_b2 and tx_d. A burst sends the words latched before its framing mark. A load made during a transmission is used by the next burst.
- R9: lof rises on the PERIOD_BITS-th bit tick after the latest framing mark when no new burst has started. It clears when a burst is completely received. A burst whose framing mark arrives while lof is 1 is decoded but not answered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_load | input | 1 | Latch the transmit channel words |
| tx_b1 | input | 16 | Bearer channel 1 word to send |
| tx_b2 | input | 16 | Bearer channel 2 word to send |
| tx_d | input | 4 | Signalling channel bits to send |
| rx_sym | input | 2 | Received line symbol |
| tx_sym | output | 2 | Transmitted line symbol |
| line_tick | output | 1 | Line bit clock strobe |
| rx_b1 | output | 16 | Received bearer channel 1 word |
| rx_b2 | output | 16 | Received bearer channel 2 word |
| rx_d | output | 4 | Received signalling bits |
| rx_valid | output | 1 | One-clock strobe for a new received burst |
| lof | output | 1 | Loss-of-frame flag |

## Verification
Random channel words go through both directions, and every outgoing symbol is compared against a bench-built AMI stream. This catches a wrong slot order, a wrong bit order within a word and a polarity memory that resets between bursts. Directed all-zero, all-one and alternating words are also sent. The all-zero words leave only framing marks on the line, and the all-one words stress mark alternation. A changed load in the middle of a transmission shows whether the snapshot is taken at the framing mark. A silence one tick longer than the repetition period pins down the exact moment lof rises. The burst that follows the silence shows that lof suppresses the answer and that a complete burst clears it.

// File: rtl/lf_pkg.sv
package lf_pkg;
  localparam int B_W       = 16;
  localparam int D_W       = 4;
  localparam int HALF_B    = B_W / 2;
  localparam int HALF_D    = D_W / 2;
  localparam int GROUP     = 2 * HALF_B + HALF_D;
  localparam int DATA_BITS = 2 * GROUP;
  localparam int IDX_W     = $clog2(DATA_BITS + 1);
  localparam int POS_W     = $clog2(B_W);

  localparam logic [1:0] SYM_ZERO = 2'b00;
  localparam logic [1:0] SYM_POS  = 2'b01;
  localparam logic [1:0] SYM_NEG  = 2'b10;

  typedef enum logic [1:0] {CH_B1, CH_B2, CH_D} chan_t;
  typedef enum logic [1:0] {ST_IDLE, ST_RECV, ST_GUARD, ST_XMIT} phase_t;

  typedef struct packed {
    chan_t             ch;
    logic [POS_W-1:0]  pos;
  } slot_t;

  // Payload slot k -> channel and bit position (MSB first within each word)
  function automatic slot_t slot_of(input logic [IDX_W-1:0] k);
    slot_t s;
    int g, r;
    g = int'(k) / GROUP;
    r = int'(k) % GROUP;
    if (r < HALF_B) begin
      s.ch  = CH_B1;
      s.pos = POS_W'(B_W - 1 - (g * HALF_B + r));
    end else if (r < 2 * HALF_B) begin
      s.ch  = CH_B2;
      s.pos = POS_W'(B_W - 1 - (g * HALF_B + r - HALF_B));
    end else begin
      s.ch  = CH_D;
      s.pos = POS_W'(D_W - 1 - (g * HALF_D + r - 2 * HALF_B));
    end
    return s;
  endfunction
endpackage

// File: rtl/lf_divider.sv
module lf_divider #(
  parameter int CLKS_PER_BIT = 4
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLKS_PER_BIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      tick <= (cnt == LAST);
      cnt  <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/lf_ami_tx.sv
module lf_ami_tx (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       emit,
  input  logic       bit_in,
  output logic [1:0] sym
);
  import lf_pkg::*;

  logic neg_next;  // polarity of the next mark, kept across bursts

  always_ff @(posedge clk) begin
    if (rst) begin
      sym      <= SYM_ZERO;
      neg_next <= 1'b0;
    end else if (tick) begin
      if (emit && bit_in) begin
        sym      <= neg_next ? SYM_NEG : SYM_POS;
        neg_next <= ~neg_next;
      end else begin
        sym <= SYM_ZERO;
      end
    end
  end
endmodule

// File: rtl/lf_sched.sv
module lf_sched #(
  parameter int GUARD_BITS  = 6,
  parameter int PERIOD_BITS = 96
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    tick,
  input  logic                    rx_mark,
  output logic                    rx_cap,
  output logic                    rx_done,
  output logic [lf_pkg::IDX_W-1:0] rx_idx,
  output logic                    tx_first,
  output logic                    tx_emit,
  output logic [lf_pkg::IDX_W-1:0] tx_idx,
  output logic                    lof
);
  import lf_pkg::*;

  localparam int SPAN = (GUARD_BITS > DATA_BITS) ? GUARD_BITS : DATA_BITS;
  localparam int CW   = $clog2(SPAN + 1);
  localparam int SW   = $clog2(PERIOD_BITS + 1);

  phase_t          st;
  logic [CW-1:0]   cnt;
  logic [SW-1:0]   scnt;
  logic            answer;
  logic            start;

  assign start    = tick && (st == ST_IDLE) && rx_mark;
  assign rx_cap   = tick && (st == ST_RECV);
  assign rx_idx   = IDX_W'(cnt);
  assign rx_done  = rx_cap && (cnt == CW'(DATA_BITS - 1));
  assign tx_first = tick && (st == ST_GUARD) && (cnt == CW'(GUARD_BITS - 1));
  assign tx_emit  = tx_first || (tick && (st == ST_XMIT));
  assign tx_idx   = tx_first ? '0 : IDX_W'(cnt);

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      cnt    <= '0;
      scnt   <= '0;
      answer <= 1'b0;
      lof    <= 1'b1;
    end else if (tick) begin
      if (start)
        scnt <= '0;
      else if (scnt != SW'(PERIOD_BITS))
        scnt <= scnt + 1'b1;

      if (rx_done)
        lof <= 1'b0;
      else if (!start && scnt == SW'(PERIOD_BITS - 1))
        lof <= 1'b1;

      unique case (st)
        ST_IDLE: if (rx_mark) begin
          st     <= ST_RECV;
          cnt    <= '0;
          answer <= ~lof;
        end
        ST_RECV: if (cnt == CW'(DATA_BITS - 1)) begin
          st  <= answer ? ST_GUARD : ST_IDLE;
          cnt <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
        ST_GUARD: if (cnt == CW'(GUARD_BITS - 1)) begin
          st  <= ST_XMIT;
          cnt <= CW'(1);
        end else begin
          cnt <= cnt + 1'b1;
        end
        ST_XMIT: if (cnt == CW'(DATA_BITS)) begin
          st  <= ST_IDLE;
          cnt <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pingpong_framer.sv
module pingpong_framer #(
  parameter int CLKS_PER_BIT = 4,
  parameter int GUARD_BITS   = 6,
  parameter int PERIOD_BITS  = 96
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        tx_load,
  input  logic [15:0] tx_b1,
  input  logic [15:0] tx_b2,
  input  logic [3:0]  tx_d,
  input  logic [1:0]  rx_sym,
  output logic [1:0]  tx_sym,
  output logic        line_tick,
  output logic [15:0] rx_b1,
  output logic [15:0] rx_b2,
  output logic [3:0]  rx_d,
  output logic        rx_valid,
  output logic        lof
);
  import lf_pkg::*;

  logic             rx_cap, rx_done, tx_first, tx_emit, tx_bit, rx_bit;
  logic [IDX_W-1:0] rx_idx, tx_idx;
  logic [B_W-1:0]   hold_b1, hold_b2, work_b1, work_b2;
  logic [D_W-1:0]   hold_d, work_d;
  logic [B_W-1:0]   sh_b1, sh_b2, nx_b1, nx_b2;
  logic [D_W-1:0]   sh_d, nx_d;
  slot_t            tx_slot, rx_slot;

  lf_divider #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_div (
    .clk(clk), .rst(rst), .tick(line_tick)
  );

  lf_sched #(.GUARD_BITS(GUARD_BITS), .PERIOD_BITS(PERIOD_BITS)) u_sched (
    .clk(clk), .rst(rst), .tick(line_tick), .rx_mark(rx_bit),
    .rx_cap(rx_cap), .rx_done(rx_done), .rx_idx(rx_idx),
    .tx_first(tx_first), .tx_emit(tx_emit), .tx_idx(tx_idx), .lof(lof)
  );

  lf_ami_tx u_ami (
    .clk(clk), .rst(rst), .tick(line_tick), .emit(tx_emit),
    .bit_in(tx_bit), .sym(tx_sym)
  );

  assign rx_bit = (rx_sym != SYM_ZERO);

  // Transmit side: channel word holding and payload bit selection
  always_ff @(posedge clk) begin
    if (rst) begin
      hold_b1 <= '0; hold_b2 <= '0; hold_d <= '0;
      work_b1 <= '0; work_b2 <= '0; work_d <= '0;
    end else begin
      if (tx_load) begin
        hold_b1 <= tx_b1; hold_b2 <= tx_b2; hold_d <= tx_d;
      end
      if (tx_first) begin
        work_b1 <= hold_b1; work_b2 <= hold_b2; work_d <= hold_d;
      end
    end
  end

  always_comb begin
    tx_slot = slot_of(tx_idx - 1'b1);
    if (tx_idx == '0) tx_bit = 1'b1;
    else begin
      unique case (tx_slot.ch)
        CH_B1:   tx_bit = work_b1[tx_slot.pos];
        CH_B2:   tx_bit = work_b2[tx_slot.pos];
        default: tx_bit = work_d[tx_slot.pos[1:0]];
      endcase
    end
  end

  // Receive side: deframing into shadow words, published on completion
  always_comb begin
    rx_slot = slot_of(rx_idx);
    nx_b1 = sh_b1; nx_b2 = sh_b2; nx_d = sh_d;
    if (rx_cap) begin
      unique case (rx_slot.ch)
        CH_B1:   nx_b1[rx_slot.pos]      = rx_bit;
        CH_B2:   nx_b2[rx_slot.pos]      = rx_bit;
        default: nx_d[rx_slot.pos[1:0]]  = rx_bit;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_b1 <= '0; sh_b2 <= '0; sh_d <= '0;
      rx_b1 <= '0; rx_b2 <= '0; rx_d <= '0;
      rx_valid <= 1'b0;
    end else begin
      sh_b1 <= nx_b1; sh_b2 <= nx_b2; sh_d <= nx_d;
      rx_valid <= rx_done;
      if (rx_done) begin
        rx_b1 <= nx_b1; rx_b2 <= nx_b2; rx_d <= nx_d;
      end
    end
  end
endmodule

// File: rtl/lf_checker.sv
module lf_checker (
  input logic       clk,
  input logic       rst,
  input logic [1:0] tx_sym,
  input logic       line_tick,
  input logic       rx_valid,
  input logic       lof
);
  logic       tick_d;
  logic [1:0] last_mark;

  always_ff @(posedge clk) begin
    if (rst) begin
      tick_d    <= 1'b0;
      last_mark <= 2'b00;
    end else begin
      tick_d <= line_tick;
      if (tick_d && tx_sym != 2'b00) last_mark <= tx_sym;
    end
  end

  p_sym_legal_r7: assert property (@(posedge clk) disable iff (rst)
    tx_sym != 2'b11);

  p_mark_alternates_r7: assert property (@(posedge clk) disable iff (rst)
    (tick_d && tx_sym != 2'b00 && last_mark != 2'b00) |-> (tx_sym != last_mark));

  p_sym_on_tick_r2: assert property (@(posedge clk) disable iff (rst)
    !line_tick |=> $stable(tx_sym));

  p_valid_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  p_valid_clears_lof_r9: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> !lof);
endmodule

bind pingpong_framer lf_checker u_lf_checker (
  .clk(clk), .rst(rst), .tx_sym(tx_sym), .line_tick(line_tick),
  .rx_valid(rx_valid), .lof(lof)
);

// File: tb/sim_pingpong_framer.sv
`timescale 1ns/1ps
module sim_pingpong_framer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tx_load = 1'b0;
  logic [15:0] tx_b1 = '0, tx_b2 = '0;
  logic [3:0]  tx_d = '0;
  logic [1:0]  rx_sym = 2'b00;
  logic [1:0]  tx_sym;
  logic        line_tick, rx_valid, lof;
  logic [15:0] rx_b1, rx_b2;
  logic [3:0]  rx_d;

  int  errs = 0, checks = 0;
  bit  tpol = 1'b0, rpol = 1'b0;
  logic [15:0] hb1 = '0, hb2 = '0;
  logic [3:0]  hd = '0;

  always #2.5 clk = ~clk;

  pingpong_framer u0 (
    .clk(clk), .rst(rst), .tx_load(tx_load), .tx_b1(tx_b1), .tx_b2(tx_b2),
    .tx_d(tx_d), .rx_sym(rx_sym), .tx_sym(tx_sym), .line_tick(line_tick),
    .rx_b1(rx_b1), .rx_b2(rx_b2), .rx_d(rx_d), .rx_valid(rx_valid), .lof(lof)
  );

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // bench-side payload order: two groups of 8 B1, 8 B2, 2 D, MSB first
  function automatic logic [0:35] order(input logic [15:0] b1, input logic [15:0] b2,
                                        input logic [3:0] d);
    logic [0:35] q;
    int n = 0;
    for (int g = 0; g < 2; g++) begin
      for (int i = 0; i < 8; i++) begin q[n] = b1[15 - 8*g - i]; n++; end
      for (int i = 0; i < 8; i++) begin q[n] = b2[15 - 8*g - i]; n++; end
      for (int i = 0; i < 2; i++) begin q[n] = d[3 - 2*g - i];   n++; end
    end
    return q;
  endfunction

  function automatic logic [1:0] tx_ami(input bit b);
    logic [1:0] s = 2'b00;
    if (b) begin s = tpol ? 2'b10 : 2'b01; tpol = ~tpol; end
    return s;
  endfunction

  function automatic logic [1:0] rx_ami(input bit b);
    logic [1:0] s = 2'b00;
    if (b) begin s = rpol ? 2'b10 : 2'b01; rpol = ~rpol; end
    return s;
  endfunction

  task automatic load(input logic [15:0] b1, input logic [15:0] b2, input logic [3:0] d);
    tx_b1 = b1; tx_b2 = b2; tx_d = d; tx_load = 1'b1;
    @(negedge clk);
    tx_load = 1'b0;
    hb1 = b1; hb2 = b2; hd = d;
  endtask

  // one line bit: drive at the negedge before the tick edge, return after it
  task automatic step(input logic [1:0] s);
    do @(negedge clk); while (!line_tick);
    rx_sym = s;
    @(negedge clk);
  endtask

  // 96-tick repetition period: incoming burst, guard and (maybe) answer
  task automatic burst(input logic [15:0] b1, input logic [15:0] b2, input logic [3:0] d,
                       input bit answer, input bit reload,
                       input logic [15:0] nb1, input logic [15:0] nb2, input logic [3:0] nd);
    logic [1:0] rs [0:36];
    logic [1:0] es [0:36];
    logic [0:35] rq, tq;
    int bad = 0, bad_k = -1;
    logic [1:0] bad_a = 0, bad_e = 0, exp_s;
    rq = order(b1, b2, d);
    tq = order(hb1, hb2, hd);
    rs[0] = rx_ami(1'b1);
    for (int k = 0; k < 36; k++) rs[k+1] = rx_ami(rq[k]);
    if (answer) begin
      es[0] = tx_ami(1'b1);
      for (int k = 0; k < 36; k++) es[k+1] = tx_ami(tq[k]);
    end
    for (int k = 0; k < 96; k++) begin
      step(k < 37 ? rs[k] : 2'b00);
      exp_s = (answer && k >= 42 && k <= 78) ? es[k-42] : 2'b00;
      if (tx_sym != exp_s) begin
        bad++;
        if (bad_k < 0) begin bad_k = k; bad_a = tx_sym; bad_e = exp_s; end
      end
      if (k == 36) begin
        chk(rx_valid == 1'b1, "R4", "rx_valid after last payload bit", rx_valid, 1);
        chk(rx_b1 == b1 && rx_b2 == b2, "R3 R4", "rx bearer words",
            {rx_b1, rx_b2}, {b1, b2});
        chk(rx_d == d, "R4", "rx signalling bits", rx_d, d);
        @(negedge clk);
        chk(rx_valid == 1'b0, "R4", "rx_valid one clock", rx_valid, 0);
      end
      if (k == 60 && reload) load(nb1, nb2, nd);
    end
    chk(bad == 0, answer ? "R5 R6 R7 R8" : "R9",
        $sformatf("tx symbols (first bad tick %0d)", bad_k), bad_a, bad_e);
    chk(lof == 1'b0, "R9", "lof low within period", lof, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errs++;
    $display("FAIL watchdog expired actual=running expected=done");
    report();
  end

  initial begin
    logic [15:0] a1, a2, n1, n2;
    logic [3:0]  ad, nd;
    int gap;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    chk(tx_sym == 2'b00 && lof == 1'b1 && rx_valid == 1'b0, "R1", "state in reset",
        {tx_sym, lof, rx_valid}, 4'b0010);
    rst = 1'b0;
    @(negedge clk);
    chk(tx_sym == 2'b00 && lof == 1'b1 && rx_valid == 1'b0, "R1", "state after reset",
        {tx_sym, lof, rx_valid}, 4'b0010);

    // R2: bit clock spacing
    do @(negedge clk); while (!line_tick);
    gap = 0;
    do begin @(negedge clk); gap++; end while (!line_tick);
    chk(gap == 4, "R2", "line_tick spacing", gap, 4);

    load(16'hA5C3, 16'h0F1E, 4'h9);
    // first burst arrives while lof is set: decoded, not answered (R9)
    burst($urandom, $urandom, 4'($urandom), 1'b0, 1'b0, '0, '0, '0);

    // answered bursts: random payloads, new words loaded mid-transmission (R8)
    for (int i = 0; i < 5; i++) begin
      a1 = $urandom; a2 = $urandom; ad = 4'($urandom);
      n1 = $urandom; n2 = $urandom; nd = 4'($urandom);
      burst(a1, a2, ad, 1'b1, 1'b1, n1, n2, nd);
    end
    // directed patterns
    burst(16'h0000, 16'h0000, 4'h0, 1'b1, 1'b1, 16'hFFFF, 16'hFFFF, 4'hF);
    burst(16'hFFFF, 16'hFFFF, 4'hF, 1'b1, 1'b1, 16'hAAAA, 16'h5555, 4'hA);
    burst(16'h5555, 16'hAAAA, 4'h5, 1'b1, 1'b1, 16'h0000, 16'h0000, 4'h0);
    burst(16'h8001, 16'h7FFE, 4'h6, 1'b1, 1'b0, '0, '0, '0);

    // R9: one more silent tick completes a period without a burst
    step(2'b00);
    chk(lof == 1'b1, "R9", "lof after silent period", lof, 1);
    repeat (10) step(2'b00);
    chk(tx_sym == 2'b00, "R9", "line quiet during loss", tx_sym, 0);
    burst(16'h1234, 16'hFEDC, 4'h3, 1'b0, 1'b0, '0, '0, '0);
    burst(16'hCAFE, 16'h0BAD, 4'hC, 1'b1, 1'b0, '0, '0, '0);

    report();
  end
endmodule